// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block sits beside the inbound write path of a root port and collects message-signalled interrupts. It snoops every inbound memory write. When a full 32-bit write lands exactly on the programmed 64-bit capture address, the written data is taken as a vector number. That vector's pending bit is latched in one of several groups of 32 vectors, provided the vector is enabled.

Software programs the block through a 32-bit register port. The port holds the capture address and, for each group, an enable word, a mask word and a pending (status) word. A status bit is cleared by writing a 1 to it. A single interrupt line is raised while any pending vector is unmasked.

Top module: `msi_cap_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the capture address, every enable, mask and status word read as zero, and `irq_out` is low.
- R2: The low 32 bits of the capture address are read and written at offset 0x820. The high 32 bits are at offset 0x824.
- R3: Group n has its enable word at 0x828+12n, its mask word at 0x82C+12n and its status word at 0x830+12n. Enable and mask read back what was written. A write to a status word never sets a bit.
- R4: A snoop write hits when `snp_valid` is high, `snp_be` is 4'hF and `snp_addr` equals {high word, low word}. A hit with data v sets bit v%32 of group v/32, and the bit is visible from the next clock. The boundary vector 255 maps to bit 31 of group 7.
- R5: A hit on a vector whose enable bit is 0 leaves its status bit clear.
- R6: Writing a 1 to a status bit clears it. Writing a 0 to a status bit leaves it unchanged.
- R7: A hit whose data is 256 or more (with the default 8 groups) changes no status bit.
- R8: A snoop write with any byte enable low, or with an address differing from the capture address, changes no status bit.
- R9: `irq_out` is high exactly while some status bit is set and its mask bit is 0. It follows the registers, so it rises in the cycle after the hit.
- R10: If a hit and a write-one-to-clear target the same status bit in the same cycle, the bit ends up set.
- R11: Reads of offsets that map to no register return zero. This includes the first offset past the last group and offsets within a group stride that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| snp_valid | input | 1 | Inbound write present on the snoop port |
| snp_be | input | 4 | Byte enables of the inbound write |
| snp_addr | input | 64 | Address of the inbound write |
| snp_data | input | 32 | Data of the inbound write |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its default of 8 groups. This makes the full vector space, 0 to 255, reachable. It also puts the first out-of-range value, 256, and the first unmapped offset after the last group, 0x888, within a few writes. Because there are this many groups, a capture in group 3 or group 7 shows whether the group index is taken from the upper data bits rather than from the bit position. A behavioural model tracks every register and the interrupt line each clock.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int          REG_AW       = 12;
    localparam int          VEC_PER_GRP  = 32;
    localparam int          GRP_STRIDE   = 12;
    localparam logic [11:0] OFF_TGT_LO   = 12'h820;
    localparam logic [11:0] OFF_TGT_HI   = 12'h824;
    localparam logic [11:0] OFF_GRP_BASE = 12'h828;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TGT_LO,
        SEL_TGT_HI,
        SEL_ENABLE,
        SEL_MASK,
        SEL_STATUS
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [7:0] grp;
    } reg_dec_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] vec;
    } msi_hit_t;

    function automatic reg_dec_t decode_reg(input logic [REG_AW-1:0] addr,
                                            input int n_groups);
        reg_dec_t d;
        int off;
        int g;
        int r;
        d.sel = SEL_NONE;
        d.grp = '0;
        if (addr == OFF_TGT_LO) begin
            d.sel = SEL_TGT_LO;
        end else if (addr == OFF_TGT_HI) begin
            d.sel = SEL_TGT_HI;
        end else if (addr >= OFF_GRP_BASE) begin
            off = int'(addr) - int'(OFF_GRP_BASE);
            g   = off / GRP_STRIDE;
            r   = off % GRP_STRIDE;
            if (g < n_groups) begin
                d.grp = 8'(g);
                case (r)
                    0:       d.sel = SEL_ENABLE;
                    4:       d.sel = SEL_MASK;
                    8:       d.sel = SEL_STATUS;
                    default: d.sel = SEL_NONE;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/msi_cap_match.sv
module msi_cap_match
    import msi_cap_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic        snp_valid,
    input  logic [3:0]  snp_be,
    input  logic [63:0] snp_addr,
    input  logic [31:0] snp_data,
    input  logic [63:0] target,
    output msi_hit_t    hit
);
    localparam int NUM_VEC = NUM_GROUPS * VEC_PER_GRP;

    logic addr_ok;
    logic vec_ok;

    always_comb begin
        addr_ok   = snp_valid && (snp_be == 4'hF) && (snp_addr == target);
        vec_ok    = snp_data < 32'(NUM_VEC);
        hit.valid = addr_ok && vec_ok;
        hit.vec   = snp_data;
    end

endmodule

// File: rtl/msi_cap_group.sv
module msi_cap_group
    import msi_cap_pkg::*;
#(
    parameter int GROUP_IDX = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en_we,
    input  logic        mask_we,
    input  logic        stat_we,
    input  logic [31:0] wdata,
    input  msi_hit_t    hit,
    output logic [31:0] en_q,
    output logic [31:0] mask_q,
    output logic [31:0] stat_q
);
    logic        hit_here;
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    always_comb begin
        hit_here = hit.valid && (hit.vec[31:5] == 27'(GROUP_IDX));
        set_vec  = hit_here ? ((32'b1 << hit.vec[4:0]) & en_q) : '0;
        clr_vec  = stat_we ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (en_we)   en_q   <= wdata;
            if (mask_we) mask_q <= wdata;
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    // R5
    stat_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

    // R4
    one_new_bit_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(stat_q & ~$past(stat_q)) <= 1));

    // R10
    hit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_here && en_q[hit.vec[4:0]]) |=> stat_q[$past(hit.vec[4:0])]);

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !hit_here) |=> ((stat_q & $past(wdata)) == '0));

endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              snp_valid,
    input  logic [3:0]        snp_be,
    input  logic [63:0]       snp_addr,
    input  logic [31:0]       snp_data,
    output logic              irq_out
);
    localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int FLAT_W = NUM_GROUPS * VEC_PER_GRP;

    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
    reg_dec_t    dec;
    msi_hit_t    hit;

    logic [31:0] en_all   [NUM_GROUPS];
    logic [31:0] mask_all [NUM_GROUPS];
    logic [31:0] stat_all [NUM_GROUPS];
    logic [FLAT_W-1:0] stat_flat;
    logic [FLAT_W-1:0] live_flat;

    always_comb dec = decode_reg(reg_addr, NUM_GROUPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_lo <= '0;
            tgt_hi <= '0;
        end else if (reg_we) begin
            if (dec.sel == SEL_TGT_LO) tgt_lo <= reg_wdata;
            if (dec.sel == SEL_TGT_HI) tgt_hi <= reg_wdata;
        end
    end

    msi_cap_match #(.NUM_GROUPS(NUM_GROUPS)) u_match (
        .snp_valid (snp_valid),
        .snp_be    (snp_be),
        .snp_addr  (snp_addr),
        .snp_data  (snp_data),
        .target    ({tgt_hi, tgt_lo}),
        .hit       (hit)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic grp_sel;
        assign grp_sel = reg_we && (dec.grp == 8'(g));

        msi_cap_group #(.GROUP_IDX(g)) u_group (
            .clk     (clk),
            .rst     (rst),
            .en_we   (grp_sel && dec.sel == SEL_ENABLE),
            .mask_we (grp_sel && dec.sel == SEL_MASK),
            .stat_we (grp_sel && dec.sel == SEL_STATUS),
            .wdata   (reg_wdata),
            .hit     (hit),
            .en_q    (en_all[g]),
            .mask_q  (mask_all[g]),
            .stat_q  (stat_all[g])
        );

        assign stat_flat[g*VEC_PER_GRP +: VEC_PER_GRP] = stat_all[g];
        assign live_flat[g*VEC_PER_GRP +: VEC_PER_GRP] = stat_all[g] & ~mask_all[g];
    end

    always_comb begin
        case (dec.sel)
            SEL_TGT_LO: reg_rdata = tgt_lo;
            SEL_TGT_HI: reg_rdata = tgt_hi;
            SEL_ENABLE: reg_rdata = en_all[dec.grp[GRP_W-1:0]];
            SEL_MASK:   reg_rdata = mask_all[dec.grp[GRP_W-1:0]];
            SEL_STATUS: reg_rdata = stat_all[dec.grp[GRP_W-1:0]];
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_out = |live_flat;

    // R8
    miss_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!(snp_valid && snp_be == 4'hF && snp_addr == {tgt_hi, tgt_lo}) && !reg_we)
        |=> $stable(stat_flat));

    // R7
    range_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_data >= 32'(FLAT_W) && !reg_we) |=> $stable(stat_flat));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (stat_flat != '0));

endmodule

// File: tb/msi_cap_ctrl_bench.sv
`timescale 1ns/1ps
module msi_cap_ctrl_bench;
    localparam int NG = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        snp_valid = 1'b0;
    logic [3:0]  snp_be = '0;
    logic [63:0] snp_addr = '0;
    logic [31:0] snp_data = '0;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    msi_cap_ctrl #(.NUM_GROUPS(NG)) u_msi_cap_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .snp_valid(snp_valid),
        .snp_be(snp_be), .snp_addr(snp_addr), .snp_data(snp_data),
        .irq_out(irq_out)
    );

    // behavioural reference
    logic [63:0] m_tgt;
    logic [31:0] m_en   [NG];
    logic [31:0] m_mask [NG];
    logic [31:0] m_stat [NG];

    function automatic logic [31:0] mread(input logic [11:0] a);
        int off;
        if (a == 12'h820) return m_tgt[31:0];
        if (a == 12'h824) return m_tgt[63:32];
        if (a < 12'h828) return 32'h0;
        off = int'(a) - 'h828;
        if (off / 12 >= NG) return 32'h0;
        if (off % 12 == 0) return m_en[off / 12];
        if (off % 12 == 4) return m_mask[off / 12];
        if (off % 12 == 8) return m_stat[off / 12];
        return 32'h0;
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int i = 0; i < NG; i++) if ((m_stat[i] & ~m_mask[i]) != 0) r = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_tgt = '0;
            for (int i = 0; i < NG; i++) begin
                m_en[i] = '0; m_mask[i] = '0; m_stat[i] = '0;
            end
        end else begin
            logic        hit;
            int          v;
            hit = snp_valid && snp_be == 4'hF && snp_addr == m_tgt && snp_data < 32'(NG*32);
            v   = int'(snp_data);
            if (reg_we) begin
                if (reg_addr == 12'h820) m_tgt[31:0] = reg_wdata;
                else if (reg_addr == 12'h824) m_tgt[63:32] = reg_wdata;
                else if (reg_addr >= 12'h828) begin
                    int off;
                    off = int'(reg_addr) - 'h828;
                    if (off / 12 < NG) begin
                        if (off % 12 == 0) m_en[off / 12] = reg_wdata;
                        if (off % 12 == 4) m_mask[off / 12] = reg_wdata;
                        if (off % 12 == 8) m_stat[off / 12] = m_stat[off / 12] & ~reg_wdata;
                    end
                end
            end
            if (hit && m_en[v / 32][v % 32]) m_stat[v / 32][v % 32] = 1'b1;
        end
    end

    // every-cycle comparison of the interrupt line
    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (irq_out !== model_irq()) begin
                bad++;
                $display("FAIL R9 irq_out actual=%0b expected=%0b t=%0t", irq_out, model_irq(), $time);
            end
        end
    end

    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] wd,
                       input logic sv, input logic [3:0] be, input logic [63:0] sa,
                       input logic [31:0] sd);
        @(negedge clk); #2;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        snp_valid = sv; snp_be = be; snp_addr = sa; snp_data = sd;
        @(negedge clk); #1;
        reg_we = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 4'h0, 64'h0, 32'h0);
    endtask

    task automatic msi(input logic [63:0] sa, input logic [3:0] be, input logic [31:0] d);
        cyc(1'b0, 12'h0, 32'h0, 1'b1, be, sa, d);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #2;
        reg_addr = a;
        #3;
        total++;
        if (reg_rdata !== exp || exp !== mread(a)) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h model=%h", tag, a, reg_rdata, exp, mread(a));
        end
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk); #4;
        total++;
        if (irq_out !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_out, exp);
        end
    endtask

    localparam logic [63:0] TGT = 64'h0000_0001_1000_0040;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(12'h820, 32'h0, "R1");
        rd_chk(12'h824, 32'h0, "R1");
        for (int g = 0; g < NG; g++) begin
            rd_chk(12'(12'h828 + 12*g), 32'h0, "R1");
            rd_chk(12'(12'h830 + 12*g), 32'h0, "R1");
        end
        irq_chk(1'b0, "R1");
        // R2 target address
        wr(12'h820, TGT[31:0]);
        wr(12'h824, TGT[63:32]);
        rd_chk(12'h820, 32'h1000_0040, "R2");
        rd_chk(12'h824, 32'h0000_0001, "R2");
        // R3 enables and masks
        wr(12'h828, 32'hFFFF_FFFF);
        wr(12'h828 + 36, 32'h0000_00F0);
        wr(12'h828 + 84, 32'hFFFF_FFFF);
        wr(12'h82C + 36, 32'h0000_0010);
        rd_chk(12'h828 + 36, 32'h0000_00F0, "R3");
        rd_chk(12'h82C + 36, 32'h0000_0010, "R3");
        wr(12'h830, 32'hFFFF_FFFF);
        rd_chk(12'h830, 32'h0, "R3");
        // R4 capture in group 0
        msi(TGT, 4'hF, 32'd5);
        rd_chk(12'h830, 32'h0000_0020, "R4");
        irq_chk(1'b1, "R9");
        // R5 disabled vector in group 3
        msi(TGT, 4'hF, 32'd98);
        rd_chk(12'h830 + 36, 32'h0, "R5");
        // R4 enabled vector in group 3, masked bit 4 (R9)
        msi(TGT, 4'hF, 32'd100);
        rd_chk(12'h830 + 36, 32'h0000_0010, "R4");
        // R7 out of range
        msi(TGT, 4'hF, 32'd256);
        msi(TGT, 4'hF, 32'hFFFF_FFFF);
        rd_chk(12'h830 + 84, 32'h0, "R7");
        rd_chk(12'h830, 32'h0000_0020, "R7");
        // R8 partial write and wrong address
        msi(TGT, 4'h3, 32'd6);
        msi(TGT ^ 64'h1_0000_0000, 4'hF, 32'd6);
        msi(TGT + 64'd4, 4'hF, 32'd6);
        rd_chk(12'h830, 32'h0000_0020, "R8");
        // R6 write-one-to-clear, zero leaves
        wr(12'h830 + 36, 32'h0);
        rd_chk(12'h830 + 36, 32'h0000_0010, "R6");
        wr(12'h830, 32'h0000_0020);
        rd_chk(12'h830, 32'h0, "R6");
        // R9 only the masked bit remains
        irq_chk(1'b0, "R9");
        wr(12'h82C + 36, 32'h0);
        irq_chk(1'b1, "R9");
        wr(12'h830 + 36, 32'h0000_0010);
        irq_chk(1'b0, "R9");
        // R10 hit and clear together
        msi(TGT, 4'hF, 32'd7);
        cyc(1'b1, 12'h830, 32'h0000_0080, 1'b1, 4'hF, TGT, 32'd7);
        rd_chk(12'h830, 32'h0000_0080, "R10");
        cyc(1'b1, 12'h830, 32'h0000_0080, 1'b1, 4'hF, TGT, 32'd9);
        rd_chk(12'h830, 32'h0000_0200, "R6");
        // R4 boundary vector 255
        msi(TGT, 4'hF, 32'd255);
        rd_chk(12'h830 + 84, 32'h8000_0000, "R4");
        // R11 unmapped offsets
        wr(12'h888, 32'hFFFF_FFFF);
        rd_chk(12'h888, 32'h0, "R11");
        rd_chk(12'h82A, 32'h0, "R11");
        rd_chk(12'h81C, 32'h0, "R11");
        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk(12'h830 + 84, 32'h0, "R1");
        rd_chk(12'h820, 32'h0, "R1");
        irq_chk(1'b0, "R1");
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule